// File: doc/BRIEF.md
# Windowed Scratch RAM with Selectable Half Indexing

This block is an 8 KB on-chip scratch memory that answers a 32-bit address bus inside one upper window. The storage is two 4 KB halves. A mode input picks which address bit steers an access into the upper or the lower half, so software can lay out the two halves either far apart or next to each other in the address space. An enable input turns the memory inert.

A requester raises `req` for one cycle with an address, a size code, a write flag and write data. Writes take effect at that clock edge. A read returns its data, right-justified and zero-extended, on `rdata` in the following cycle, with `rvalid` high for that one cycle. Accesses that miss the window, are misaligned, use an undefined size code, or arrive while the enable is low leave the storage unchanged and read back zero.

Top module: `scratch_ram`

## Requirements
- R1: The RAM responds only when address bits [31:26] equal 6'b011111, which covers top bytes 0x7C to 0x7F. A read outside the window returns zero and a write outside it changes no byte.
- R2: The byte offset is {half, addr[11:0]}. The half bit is addr[25] when `idx_mode` is 1 and addr[13] when `idx_mode` is 0. The mode sampled in the cycle of the access applies.
- R3: When `ram_en` is 0, a read returns zero and a write changes no byte.
- R4: Size code 0 selects a byte, code 1 a halfword and code 2 a word. Byte order is little-endian: byte lane k holds offset bits [1:0] = k. A write updates only the lanes it covers, taking its data from the low bits of `wdata`. A read returns the addressed bytes right-justified, with zeros above them.
- R5: A halfword with addr[0] = 1, a word with addr[1:0] not equal to 0, or size code 3 is ignored. Such a read returns zero and such a write changes no byte.
- R6: `rvalid` is high exactly in the cycle after a read request (`req` = 1, `we` = 0) and low otherwise. This holds even when the read is ignored.
- R7: Reset clears every byte of the storage to zero and clears `rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Access strobe, one cycle per access |
| we | input | 1 | 1 for a write, 0 for a read |
| addr | input | 32 | Byte address |
| size | input | 2 | 0 byte, 1 halfword, 2 word, 3 undefined |
| wdata | input | 32 | Write data, right-justified |
| ram_en | input | 1 | Memory enable |
| idx_mode | input | 1 | Half-select mode: 1 uses addr[25], 0 uses addr[13] |
| rdata | output | 32 | Read data, valid while rvalid is high |
| rvalid | output | 1 | Read response strobe |

## Verification
The control inputs and the access interact within a single cycle. A change of `idx_mode` or `ram_en` can land in the same cycle as a request, and the request must then use the new setting, not the one from the cycle before. The bench changes both inputs randomly on every request, often flipping them against the previous access. It also writes one half, switches the mode in the same cycle as the read-back, and judges each response against a byte-level model that resolves the half bit with the mode of that cycle.

// File: rtl/scratch_ram.sv
module scratch_ram (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        we,
  input  logic [31:0] addr,
  input  logic [1:0]  size,
  input  logic [31:0] wdata,
  input  logic        ram_en,
  input  logic        idx_mode,
  output logic [31:0] rdata,
  output logic        rvalid
);
  localparam int unsigned LOW_W  = 12;
  localparam int unsigned OFF_W  = LOW_W + 1;
  localparam int unsigned WORDS  = (1 << OFF_W) / 4;
  localparam int unsigned WIDX_W = OFF_W - 2;

  logic [31:0] mem [WORDS];

  logic              in_win, aligned, go, half;
  logic [WIDX_W-1:0] widx;
  logic [3:0]        be;
  logic [31:0]       wword, shifted, rmask;

  assign in_win  = addr[31:26] == 6'b011111;
  assign aligned = (size == 2'd0) ||
                   (size == 2'd1 && !addr[0]) ||
                   (size == 2'd2 && addr[1:0] == 2'd0);
  assign go      = req && in_win && aligned && ram_en;
  assign half    = idx_mode ? addr[25] : addr[13];
  assign widx    = {half, addr[LOW_W-1:2]};
  assign shifted = mem[widx] >> {addr[1:0], 3'b000};

  always_comb begin
    case (size)
      2'd0:    begin be = 4'b0001 << addr[1:0]; wword = {4{wdata[7:0]}};  rmask = 32'h0000_00ff; end
      2'd1:    begin be = 4'b0011 << addr[1:0]; wword = {2{wdata[15:0]}}; rmask = 32'h0000_ffff; end
      default: begin be = 4'b1111;              wword = wdata;            rmask = 32'hffff_ffff; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else if (go && we) begin
      for (int b = 0; b < 4; b++)
        if (be[b]) mem[widx][8*b +: 8] <= wword[8*b +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= req && !we;
      if (req && !we) rdata <= go ? (shifted & rmask) : 32'h0;
    end
  end

  a_r6_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !we) |=> rvalid);
  a_r6_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !(req && !we) |=> !rvalid);
  a_r1_outside_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !we && !in_win) |=> rdata == 32'h0);
  a_r3_disabled_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !we && !ram_en) |=> rdata == 32'h0);
  a_r5_misaligned_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !we && !aligned) |=> rdata == 32'h0);
  a_r4_byte_width: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !we && size == 2'd0) |=> rdata[31:8] == 24'h0);
endmodule

// File: tb/test_scratch_ram.sv
module test_scratch_ram;
  localparam int PERIOD = 10;

  logic        clk = 0, rst_n = 0, req = 0, we = 0, ram_en = 0, idx_mode = 0;
  logic [31:0] addr = 0, wdata = 0;
  logic [1:0]  size = 0;
  logic [31:0] rdata;
  logic        rvalid;

  int tests = 0, fails = 0;
  logic [7:0] model [8192];

  always #(PERIOD/2) clk = ~clk;

  scratch_ram i_scratch_ram (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .size(size),
    .wdata(wdata), .ram_en(ram_en), .idx_mode(idx_mode), .rdata(rdata), .rvalid(rvalid));

  function automatic bit hits(input logic [31:0] a, input logic [1:0] s, input logic en);
    bit al;
    al = (s == 0) || (s == 1 && a[0] == 0) || (s == 2 && a[1:0] == 0);
    return (a[31:24] >= 8'h7C) && (a[31:24] <= 8'h7F) && al && en;
  endfunction

  function automatic int offs(input logic [31:0] a, input logic m);
    return {(m ? a[25] : a[13]), a[11:0]};
  endfunction

  function automatic int nbytes(input logic [1:0] s);
    return (s == 0) ? 1 : (s == 1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] exp_read(input logic [31:0] a, input logic [1:0] s,
                                           input logic en, input logic m);
    logic [31:0] v = 0;
    if (!hits(a, s, en)) return 0;
    for (int k = 0; k < nbytes(s); k++) v[8*k +: 8] = model[offs(a, m) + k];
    return v;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(input string tag, input logic w, input logic [31:0] a,
                        input logic [1:0] s, input logic [31:0] d,
                        input logic en, input logic m);
    logic [31:0] e;
    e = exp_read(a, s, en, m);
    req = 1; we = w; addr = a; size = s; wdata = d; ram_en = en; idx_mode = m;
    @(negedge clk);
    req = 0;
    if (w) begin
      if (hits(a, s, en))
        for (int k = 0; k < nbytes(s); k++) model[offs(a, m) + k] = d[8*k +: 8];
      check({tag, " no valid after write (R6)"}, {31'h0, rvalid}, 32'h0);
    end else begin
      check({tag, " valid (R6)"}, {31'h0, rvalid}, 32'h1);
      check({tag, " data"}, rdata, e);
    end
  endtask

  task automatic do_reset;
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < 8192; i++) model[i] = 0;
    @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int unsigned seed;
    logic [31:0] a;
    seed = 32'd1234;
    void'($urandom(seed));
    do_reset();
    check("R7 rvalid after reset", {31'h0, rvalid}, 32'h0);
    access("R7 cleared word", 0, 32'h7C00_0100, 2, 0, 1, 0);
    access("R7 cleared upper half", 0, 32'h7E00_1FFC, 2, 0, 1, 1);

    // R2: same low offset, half picked by addr[25] or addr[13]
    access("R2 wr lower m1", 1, 32'h7C00_0010, 0, 32'hAA, 1, 1);
    access("R2 wr upper m1", 1, 32'h7E00_0010, 0, 32'h55, 1, 1);
    access("R2 rd bit13 m0", 0, 32'h7C00_2010, 0, 0, 1, 0);
    access("R2 rd bit25 m0", 0, 32'h7E00_0010, 0, 0, 1, 0);
    access("R2 rd bit25 m1", 0, 32'h7E00_2010, 0, 0, 1, 1);
    // R4 lanes
    access("R4 wr word", 1, 32'h7D00_0040, 2, 32'h1122_3344, 1, 0);
    access("R4 wr byte lane2", 1, 32'h7D00_0042, 0, 32'hFFFF_FF99, 1, 0);
    access("R4 rd word", 0, 32'h7D00_0040, 2, 0, 1, 0);
    access("R4 rd half hi", 0, 32'h7D00_0042, 1, 0, 1, 0);
    // R5 misaligned / bad size
    access("R5 misaligned word wr", 1, 32'h7D00_0041, 2, 32'hDEAD_BEEF, 1, 0);
    access("R5 size3 wr", 1, 32'h7D00_0040, 3, 32'hDEAD_BEEF, 1, 0);
    access("R5 rd after ignored", 0, 32'h7D00_0040, 2, 0, 1, 0);
    access("R5 misaligned half rd", 0, 32'h7D00_0041, 1, 0, 1, 0);
    // R3 disabled
    access("R3 wr disabled", 1, 32'h7D00_0040, 2, 32'h0BAD_0BAD, 0, 0);
    access("R3 rd disabled", 0, 32'h7D00_0040, 2, 0, 0, 0);
    access("R3 rd enabled again", 0, 32'h7D00_0040, 2, 0, 1, 0);
    // R1 window edges
    access("R1 wr outside", 1, 32'h7B00_0040, 2, 32'hCAFE_F00D, 1, 0);
    access("R1 wr outside hi", 1, 32'h8000_0040, 2, 32'hCAFE_F00D, 1, 0);
    access("R1 rd outside", 0, 32'h8000_0040, 2, 0, 1, 0);
    access("R1 rd inside edge", 0, 32'h7F00_0040, 2, 0, 1, 0);
    // R6 idle cycle
    @(negedge clk);
    check("R6 idle no valid", {31'h0, rvalid}, 32'h0);

    // random mix, control inputs changing with each request
    for (int n = 0; n < 3000; n++) begin
      a = $urandom;
      a[31:24] = ($urandom % 10 == 0) ? 8'h7B : 8'h7C + 8'($urandom % 4);
      a[11:0]  = 12'($urandom % 64);
      access("R4 random", 1'($urandom), a, 2'($urandom), $urandom,
             ($urandom % 8) != 0, 1'($urandom));
    end

    // R7: mid-run reset clears contents
    access("R7 pre", 1, 32'h7C00_0020, 2, 32'h5A5A_5A5A, 1, 0);
    do_reset();
    access("R7 after reset", 0, 32'h7C00_0020, 2, 0, 1, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule